// File: doc/BRIEF.md
# Parallel Prefix Automaton State Evaluator

This block takes an N-bit input string and a start state, and returns in one pass the state that a fixed four-state automaton holds after each prefix of that string. The automaton counts consecutive ones. A zero sends it back to its first state, a one moves it up by one state, and the last state absorbs every input. Bit 0 of the input string is consumed first.

The block does not chain N next-state circuits in a row. Each input bit becomes a small transition function, held as a table of four next-state entries. A Sklansky-style prefix tree with log2 N levels then composes these tables, so every prefix function is ready at once. A last stage applies each prefix function to the start state. An optional register stage captures the inputs and the outputs, which lets the tree sit between two clock edges.

Top module: `dfa_prefix_eval`

## Requirements
- R1: The block works for any power-of-two N of at least 2. Any other N stops elaboration with an error.
- R2: With PIPE=1, an active-low reset clears the registers, and every output state reads 0 while reset is held and until new inputs have passed through.
- R3: Under input bit 0, states 0, 1 and 2 go to state 0, and state 3 stays in state 3.
- R4: Under input bit 1, state k goes to state k+1 for k below 3, and state 3 stays in state 3.
- R5: Output slot i, at states_o bits [2i+1:2i], holds the state reached after applying bits 0 through i in ascending order, starting from start_i. State sk is encoded as the binary value k.
- R6: Output slot 0 depends only on start_i and bits_i[0].
- R7: With PIPE=1, an output reflects the inputs applied two rising edges earlier and holds its value across the first of those edges. With PIPE=0, the outputs are purely combinational.
- R8: Once some slot reads state 3, every higher slot also reads state 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Active-low synchronous reset for the register stage |
| bits_i | input | N | Input string; bit 0 is consumed first |
| start_i | input | 2 | Start state, binary encoded |
| states_o | output | 2*N | Prefix states; slot i is at bits [2i+1:2i] |

## Verification
The bound checker compares neighbouring output slots on every cycle. A slot that reads state 3 must be followed by state 3. Otherwise the next slot must be one higher or zero, depending on the matching delayed input bit, and slot 0 must agree with the delayed start state and first bit. Together these rules pin down the transition rules and the ordering of composition. The reset contents, the two-edge latency with its hold across the first edge, the combinational variant at a second width, and full agreement with a sequential reference over random and directed strings are shown only by the bench scenarios.

// File: rtl/dfa_pp_pkg.sv
package dfa_pp_pkg;

   // A transition function: entry k is the next state from state k.
   typedef logic [1:0] st_t;
   typedef st_t [3:0] fn_t;

   localparam st_t ST_TOP = 2'd3;

   // Transition table for a single input symbol.
   function automatic fn_t sym_fn(input logic sym);
      fn_t r;
      for (int k = 0; k < 4; k++) begin
         if (k == 3)   r[k] = ST_TOP;
         else if (sym) r[k] = st_t'(k + 1);
         else          r[k] = 2'd0;
      end
      return r;
   endfunction

   // outer after inner: r[k] = outer[inner[k]].
   function automatic fn_t fn_compose(input fn_t outer, input fn_t inner);
      fn_t r;
      for (int k = 0; k < 4; k++) r[k] = outer[inner[k]];
      return r;
   endfunction

endpackage

// File: rtl/dfa_sym_map.sv
module dfa_sym_map
   import dfa_pp_pkg::*;
#(
   parameter int N = 8
) (
   input  logic    [N-1:0] bits_i,
   output fn_t     [N-1:0] fn_o
);
   for (genvar i = 0; i < N; i++) begin : g_sym
      assign fn_o[i] = sym_fn(bits_i[i]);
   end
endmodule

// File: rtl/dfa_prefix_tree.sv
module dfa_prefix_tree
   import dfa_pp_pkg::*;
#(
   parameter int N = 8
) (
   input  fn_t [N-1:0] leaf_i,
   output fn_t [N-1:0] pre_o
);
   localparam int LG = $clog2(N);

   fn_t [N-1:0] lvl [LG+1];

   assign lvl[0] = leaf_i;

   for (genvar l = 0; l < LG; l++) begin : g_lvl
      for (genvar i = 0; i < N; i++) begin : g_node
         // Last index of the lower block that this upper-half node joins.
         localparam int J = ((i >> l) << l) - 1;
         if (((i >> l) & 1) == 1) begin : g_join
            assign lvl[l+1][i] = fn_compose(lvl[l][i], lvl[l][J]);
         end else begin : g_pass
            assign lvl[l+1][i] = lvl[l][i];
         end
      end
   end

   assign pre_o = lvl[LG];
endmodule

// File: rtl/dfa_apply.sv
module dfa_apply
   import dfa_pp_pkg::*;
#(
   parameter int N = 8
) (
   input  fn_t  [N-1:0]   pre_i,
   input  st_t            start_i,
   output logic [2*N-1:0] states_o
);
   for (genvar i = 0; i < N; i++) begin : g_app
      assign states_o[2*i +: 2] = pre_i[i][start_i];
   end
endmodule

// File: rtl/dfa_prefix_eval.sv
module dfa_prefix_eval
   import dfa_pp_pkg::*;
#(
   parameter int N    = 8,
   parameter bit PIPE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   bits_i,
   input  logic [1:0]     start_i,
   output logic [2*N-1:0] states_o
);
   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("dfa_prefix_eval: N must be a power of two >= 2");
   end

   logic [N-1:0]   bits_q;
   st_t            start_q;
   logic [2*N-1:0] core_st;
   fn_t  [N-1:0]   leaf_fn;
   fn_t  [N-1:0]   pre_fn;

   if (PIPE) begin : g_reg
      logic [2*N-1:0] out_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bits_q  <= '0;
            start_q <= '0;
            out_q   <= '0;
         end else begin
            bits_q  <= bits_i;
            start_q <= start_i;
            out_q   <= core_st;
         end
      end
      assign states_o = out_q;
   end else begin : g_comb
      assign bits_q   = bits_i;
      assign start_q  = start_i;
      assign states_o = core_st;
   end

   dfa_sym_map #(.N(N)) u_map (
      .bits_i (bits_q),
      .fn_o   (leaf_fn)
   );

   dfa_prefix_tree #(.N(N)) u_tree (
      .leaf_i (leaf_fn),
      .pre_o  (pre_fn)
   );

   dfa_apply #(.N(N)) u_apply (
      .pre_i    (pre_fn),
      .start_i  (start_q),
      .states_o (core_st)
   );
endmodule

// File: rtl/dfa_prefix_eval_chk.sv
module dfa_prefix_eval_chk #(
   parameter int N    = 8,
   parameter bit PIPE = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   bits_i,
   input logic [1:0]     start_i,
   input logic [2*N-1:0] states_o
);
   logic [N-1:0] d_bits;
   logic [1:0]   d_start;

   if (PIPE) begin : g_dly
      logic [N-1:0] b1, b2;
      logic [1:0]   s1, s2;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b1 <= '0; b2 <= '0; s1 <= '0; s2 <= '0;
         end else begin
            b1 <= bits_i;  b2 <= b1;
            s1 <= start_i; s2 <= s1;
         end
      end
      assign d_bits  = b2;
      assign d_start = s2;
   end else begin : g_nodly
      assign d_bits  = bits_i;
      assign d_start = start_i;
   end

   logic [1:0] first_exp;
   always_comb begin
      if (d_start == 2'd3)  first_exp = 2'd3;
      else if (d_bits[0])   first_exp = d_start + 2'd1;
      else                  first_exp = 2'd0;
   end

   // R6, R5: slot 0 follows start state and bit 0
   p_first_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      states_o[1:0] == first_exp);

   for (genvar i = 0; i < N - 1; i++) begin : g_pair
      // R8: state 3 absorbs
      p_sink_r8: assert property (@(posedge clk) disable iff (!rst_n)
         states_o[2*i +: 2] == 2'd3 |-> states_o[2*(i+1) +: 2] == 2'd3);
      // R4: one moves up by one
      p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (d_bits[i+1] && states_o[2*i +: 2] != 2'd3)
         |-> states_o[2*(i+1) +: 2] == states_o[2*i +: 2] + 2'd1);
      // R3: zero returns to state 0
      p_step_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!d_bits[i+1] && states_o[2*i +: 2] != 2'd3)
         |-> states_o[2*(i+1) +: 2] == 2'd0);
   end
endmodule

bind dfa_prefix_eval dfa_prefix_eval_chk #(.N(N), .PIPE(PIPE)) u_chk (.*);

// File: tb/tb_dfa_prefix_eval.sv
module tb_dfa_prefix_eval;
   localparam int N  = 8;
   localparam int N2 = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [N-1:0]    bits;
   logic [1:0]      start;
   logic [2*N-1:0]  st;
   logic [N2-1:0]   bits2;
   logic [1:0]      start2;
   logic [2*N2-1:0] st2;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   dfa_prefix_eval #(.N(N), .PIPE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .bits_i(bits), .start_i(start), .states_o(st));

   dfa_prefix_eval #(.N(N2), .PIPE(1'b0)) dut_comb (
      .clk(clk), .rst_n(rst_n), .bits_i(bits2), .start_i(start2), .states_o(st2));

   // Sequential reference run of the automaton.
   function automatic logic [2*N2-1:0] ref_run(input logic [N2-1:0] b,
                                               input logic [1:0] s0, input int n);
      logic [2*N2-1:0] r = '0;
      logic [1:0] s = s0;
      for (int i = 0; i < n; i++) begin
         if (s == 2'd3)   s = 2'd3;
         else if (b[i])   s = s + 2'd1;
         else             s = 2'd0;
         r[2*i +: 2] = s;
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [2*N2-1:0] act,
                      input logic [2*N2-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Apply to the registered instance and sample after two edges.
   task automatic run8(input string req, input logic [N-1:0] b, input logic [1:0] s);
      @(negedge clk);
      bits = b; start = s;
      @(posedge clk); @(posedge clk); #1;
      chk(req, {{(2*(N2-N)){1'b0}}, st}, ref_run({{(N2-N){1'b0}}, b}, s, N));
   endtask

   task automatic run16(input string req, input logic [N2-1:0] b, input logic [1:0] s);
      bits2 = b; start2 = s;
      #1;
      chk(req, st2, ref_run(b, s, N2));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      bits = '1; start = 2'd2; bits2 = '0; start2 = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R2 reset clears", {{(2*(N2-N)){1'b0}}, st}, '0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R2 after release", {{(2*(N2-N)){1'b0}}, st}, '0);

      // R3: all zeros from each start
      for (int s = 0; s < 4; s++) run8("R3 zeros", '0, 2'(s));
      // R4: all ones from each start
      for (int s = 0; s < 4; s++) run8("R4 ones", '1, 2'(s));
      // R8: reaching state 3 absorbs later zeros
      run8("R8 absorb", 8'b0000_0111, 2'd0);
      run8("R8 start top", 8'b0101_0000, 2'd3);
      // R5: ordering, bit 0 first
      run8("R5 order", 8'b1110_0000, 2'd0);
      run8("R5 alternate", 8'b1010_1010, 2'd1);
      // R6: slot 0 from start and bit 0
      run8("R6 first", 8'b0000_0001, 2'd2);
      run8("R6 first zero", 8'b1111_1110, 2'd2);

      // R7: hold across the first edge, update on the second
      run8("R7 setup", 8'h00, 2'd0);
      @(negedge clk); bits = 8'b0000_0011; start = 2'd1;
      @(posedge clk); #1;
      chk("R7 hold", {{(2*(N2-N)){1'b0}}, st}, ref_run(16'h0, 2'd0, N));
      @(posedge clk); #1;
      chk("R7 update", {{(2*(N2-N)){1'b0}}, st}, ref_run(16'h0003, 2'd1, N));

      // R5: random strings
      for (int k = 0; k < 200; k++) run8("R5 random", N'($urandom), 2'($urandom));

      // R1, R7: combinational variant at a second width
      run16("R1 comb zeros", '0, 2'd1);
      run16("R1 comb ones", '1, 2'd0);
      run16("R8 comb absorb", 16'h0007, 2'd0);
      for (int k = 0; k < 100; k++) run16("R7 comb random", N2'($urandom), 2'($urandom));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule